// File: doc/BRIEF.md
# Serial Clock-Control Register Slave

This block is a two-wire serial slave that holds the byte-wide control bank of a clock generator. The bank decides which output clocks run or stop, whether spread-spectrum modulation is on and of which kind, whether every output is floated, and which 4-bit frequency code the synthesizer uses. A host writes the bank with a block transfer. After the address byte it sends two filler bytes, a command byte and a length byte. The slave acknowledges both and discards them. Every byte after that lands in the next register, starting at index 0. A read transfer returns the length byte followed by the eight registers.

Four frequency-select strap pins and one ratio-select strap pin are captured once, on the first clock after power-on reset ends. Those captured values are visible in read-only bit positions. A source-select bit decides whether the synthesizer follows the straps or the software code. Both bus lines are synchronised and deglitched before any edge or START/STOP is recognised.

Sequencer states: `ST_IDLE` (bus free), `ST_ADDR` (address byte shifting in), `ST_ACK_ADDR`, `ST_CMD`, `ST_ACK_CMD`, `ST_CNT`, `ST_ACK_CNT`, `ST_WR` (data byte shifting in), `ST_ACK_WR`, `ST_RD` (byte shifting out) and `ST_RD_ACK` (master's acknowledge bit). Transitions:
- START moves any state to `ST_ADDR`. STOP moves any state to `ST_IDLE`.
- `ST_ADDR` moves to `ST_ACK_ADDR` on a matching address, and to `ST_IDLE` otherwise.
- Each receiving state moves to its acknowledge state on the falling SCL edge that ends its eighth bit.
- `ST_ACK_ADDR` moves to `ST_RD` for a read and to `ST_CMD` for a write.
- `ST_ACK_CMD` moves to `ST_CNT`. `ST_ACK_CNT` and `ST_ACK_WR` move to `ST_WR`.
- `ST_RD` moves to `ST_RD_ACK` after its eighth bit.
- `ST_RD_ACK` returns to `ST_RD` when the master acknowledges, and goes to `ST_IDLE` when it does not.

Top module: `clkgen_ctrl_regs`

## Requirements
- R1: After power-on reset the bank holds index 0 = 0x00, index 1 low five bits = 1, index 2 = 0xFF, index 3 = 0xFF, index 4 = 0x6B (bits 6, 5, 3, 1, 0 set), index 5 = 0x00. Only the reset input reloads these values.
- R2: In a write transfer the two bytes following the address (command, then length) are each acknowledged (SDA low on the ninth clock), and their values alter no register.
- R3: Data bytes of a write transfer go to indices 0, 1, 2, … in order, each acknowledged. Bytes past index 7 are acknowledged and dropped.
- R4: Indices 6 and 7 always read 0x92 and 0x02, whatever is written to them.
- R5: The straps are captured on the first clock after reset release and never change afterwards. The captured values read back at index 1 bits 7, 6, 5 = FS3, FS2, FS0, at index 4 bit 2 = FS1 and at index 4 bit 7 = ratio strap. Writes to those bits have no effect.
- R6: When index 0 bit 3 is 0, `freq_code` equals the captured straps and `ratio_sel` equals the captured ratio strap. When it is 1, `freq_code` = {idx0[2], idx0[6], idx0[5], idx0[4]} and `ratio_sel` = idx1[1].
- R7: `spread_down` = idx0[7], `spread_en` = idx0[1], `tristate_all` = idx0[0].
- R8: Enables, 1 = run: `en_fixed` = idx1[4:2], `en_sdram_f` = idx1[0], `en_sdram` = idx2, `en_pci` = idx3, `en_mid` = idx4[6:5], `en_ioapic` = idx4[3], `en_cpu` = idx4[1:0].
- R9: A read transfer returns 0x08 first, then indices 0 to 7, then repeats from 0x08 while the master acknowledges. A master NACK releases SDA and ends the transfer, and the next read again starts at 0x08.
- R10: An address byte other than `DEV_ADDR` (default 0x69, write = R/W bit 0) is not acknowledged, and the bytes after it change nothing.
- R11: A START in the middle of a transfer restarts the sequencer, so the next write's first data byte lands in index 0. A STOP returns the slave to idle with SDA released.
- R12: A pulse on SDA shorter than `FILT_LEN` clocks while SCL is high is neither a START nor a STOP and does not disturb the byte being transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Pull SDA low when 1 |
| strap_fs | input | 4 | Frequency-select strap pins |
| strap_ratio | input | 1 | Ratio-select strap pin |
| freq_code | output | 4 | Effective frequency code |
| ratio_sel | output | 1 | Effective ratio select |
| spread_en | output | 1 | Spread-spectrum enable |
| spread_down | output | 1 | Spread type, 1 = down spread |
| tristate_all | output | 1 | Float all clock outputs |
| en_fixed | output | 3 | Fixed-rate clock enables |
| en_sdram_f | output | 1 | Free-running memory clock enable |
| en_sdram | output | 8 | Memory clock enables |
| en_pci | output | 8 | Peripheral bus clock enables |
| en_mid | output | 2 | Mid-rate clock enables |
| en_ioapic | output | 1 | Interrupt controller clock enable |
| en_cpu | output | 2 | Processor clock enables |

## Verification
The bench mixes seeded random write lengths and data (including writes that run past index 7) with directed cases.
- Strap pins are changed after reset. A design that keeps sampling them would show new values at index 1 and 4 and on `freq_code`.
- A write is cut by a repeated START after three bits. A sequencer that did not restart would place the next byte at index 2.
- A read is ended with NACK after three bytes. A slave that did not release SDA would corrupt the STOP, and one that kept its pointer would begin the next read at the wrong byte.
- A one-clock SDA pulse is injected while SCL is high. Without the filter this would look like a STOP and drop the rest of the transfer.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
    localparam int NREG  = 8;
    localparam int NRW   = 6;
    localparam int IDX_W = $clog2(NREG);
    localparam int PTR_W = $clog2(NREG + 1);
    localparam int FS_W  = 4;
    localparam logic [7:0] ID_HI = 8'h92;
    localparam logic [7:0] ID_LO = 8'h02;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_ACK_ADDR, ST_CMD, ST_ACK_CMD, ST_CNT,
        ST_ACK_CNT, ST_WR, ST_ACK_WR, ST_RD, ST_RD_ACK
    } bus_state_e;

    function automatic logic [7:0] rst_val(int i);
        case (i)
            1:       return 8'h1F;
            2, 3:    return 8'hFF;
            4:       return 8'h6B;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] wmask(int i);
        case (i)
            1:       return 8'h1F;
            4:       return 8'h7B;
            default: return 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/ccr_line_filter.sv
module ccr_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          flip;

    assign flip   = (sync_q[1] != level_o) && (cnt_q == CW'(FILT_LEN - 1));
    assign rise_o = flip && sync_q[1];
    assign fall_o = flip && !sync_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= 2'b11;
            level_o <= 1'b1;
            cnt_q   <= '0;
        end else begin
            sync_q <= {sync_q[0], line_i};
            if (sync_q[1] == level_o) begin
                cnt_q <= '0;
            end else if (flip) begin
                level_o <= sync_q[1];
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_FILT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rise_o) |-> level_o); // R12
endmodule

// File: rtl/ccr_i2c_fsm.sv
module ccr_i2c_fsm import ccr_pkg::*; #(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_lvl,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             sda_lvl,
    input  logic             sda_rise,
    input  logic             sda_fall,
    input  logic [7:0]       rd_data,
    output logic [PTR_W-1:0] rd_sel,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data
);
    bus_state_e       state_q;
    logic [3:0]       bit_q;
    logic [7:0]       sh_q;
    logic             rw_q, mack_q;
    logic [PTR_W-1:0] ptr_q;
    logic             start_ev, stop_ev, rx_state, byte_done;

    assign start_ev  = sda_fall && scl_lvl;
    assign stop_ev   = sda_rise && scl_lvl;
    assign rx_state  = state_q inside {ST_ADDR, ST_CMD, ST_CNT, ST_WR};
    assign byte_done = (bit_q == 4'd8);

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            sh_q    <= '0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
            ptr_q   <= '0;
        end else if (stop_ev) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            ptr_q   <= '0;
        end else if (start_ev) begin
            state_q <= ST_ADDR;
            bit_q   <= '0;
            ptr_q   <= '0;
        end else begin
            if (scl_rise && rx_state) begin
                sh_q  <= {sh_q[6:0], sda_lvl};
                bit_q <= bit_q + 1'b1;
            end
            if (scl_rise && state_q == ST_RD_ACK) mack_q <= !sda_lvl;
            if (scl_fall) begin
                unique case (state_q)
                    ST_ADDR: if (byte_done) begin
                        bit_q   <= '0;
                        rw_q    <= sh_q[0];
                        state_q <= (sh_q[7:1] == DEV_ADDR) ? ST_ACK_ADDR : ST_IDLE;
                    end
                    ST_CMD: if (byte_done) begin
                        bit_q   <= '0;
                        state_q <= ST_ACK_CMD;
                    end
                    ST_CNT: if (byte_done) begin
                        bit_q   <= '0;
                        state_q <= ST_ACK_CNT;
                    end
                    ST_WR: if (byte_done) begin
                        bit_q   <= '0;
                        state_q <= ST_ACK_WR;
                        if (ptr_q != PTR_W'(NREG)) ptr_q <= ptr_q + 1'b1;
                    end
                    ST_ACK_ADDR: begin
                        if (rw_q) begin
                            state_q <= ST_RD;
                            sh_q    <= rd_data;
                            bit_q   <= '0;
                        end else begin
                            state_q <= ST_CMD;
                        end
                    end
                    ST_ACK_CMD: state_q <= ST_CNT;
                    ST_ACK_CNT, ST_ACK_WR: state_q <= ST_WR;
                    ST_RD: begin
                        if (bit_q == 4'd7) begin
                            state_q <= ST_RD_ACK;
                            bit_q   <= '0;
                            ptr_q   <= (ptr_q == PTR_W'(NREG)) ? '0 : ptr_q + 1'b1;
                        end else begin
                            sh_q  <= {sh_q[6:0], 1'b0};
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                    ST_RD_ACK: begin
                        if (mack_q) begin
                            state_q <= ST_RD;
                            sh_q    <= rd_data;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_ACK_ADDR, ST_ACK_CMD, ST_ACK_CNT, ST_ACK_WR: sda_oe = 1'b1;
            ST_RD:                                          sda_oe = !sh_q[7];
            default:                                        sda_oe = 1'b0;
        endcase
        wr_en   = (state_q == ST_WR) && scl_fall && byte_done && (ptr_q < PTR_W'(NREG))
                  && !start_ev && !stop_ev;
        wr_idx  = ptr_q[IDX_W-1:0];
        wr_data = sh_q;
        rd_sel  = ptr_q;
    end

    AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev && !stop_ev) |=> (state_q == ST_ADDR) && (ptr_q == '0)); // R11
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state_q == ST_IDLE) && !sda_oe); // R11
    AST_WR_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr_q == $past(ptr_q) + 1'b1)); // R3
    AST_NO_WR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !rw_q); // R9
endmodule

// File: rtl/ccr_regbank.sv
module ccr_regbank import ccr_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FS_W-1:0]  strap_fs,
    input  logic             strap_ratio,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [PTR_W-1:0] rd_sel,
    output logic [7:0]       rd_data,
    output logic [FS_W-1:0]  freq_code,
    output logic             ratio_sel,
    output logic             spread_en,
    output logic             spread_down,
    output logic             tristate_all,
    output logic [2:0]       en_fixed,
    output logic             en_sdram_f,
    output logic [7:0]       en_sdram,
    output logic [7:0]       en_pci,
    output logic [1:0]       en_mid,
    output logic             en_ioapic,
    output logic [1:0]       en_cpu
);
    logic [NRW-1:0][7:0] ctl_q;
    logic [FS_W-1:0]     fs_q;
    logic                ratio_q, strap_done_q;
    logic [PTR_W-1:0]    idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NRW; i++) ctl_q[i] <= rst_val(i);
        end else if (wr_en && (wr_idx < IDX_W'(NRW))) begin
            ctl_q[wr_idx] <= (ctl_q[wr_idx] & ~wmask(int'(wr_idx)))
                           | (wr_data & wmask(int'(wr_idx)));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strap_done_q <= 1'b0;
            fs_q         <= '0;
            ratio_q      <= 1'b0;
        end else if (!strap_done_q) begin
            strap_done_q <= 1'b1;
            fs_q         <= strap_fs;
            ratio_q      <= strap_ratio;
        end
    end

    assign idx = rd_sel - 1'b1;

    always_comb begin
        rd_data = 8'h00;
        if (rd_sel == '0) begin
            rd_data = 8'(NREG);
        end else begin
            case (idx)
                PTR_W'(0): rd_data = ctl_q[0];
                PTR_W'(1): rd_data = {fs_q[3], fs_q[2], fs_q[0], ctl_q[1][4:0]};
                PTR_W'(2): rd_data = ctl_q[2];
                PTR_W'(3): rd_data = ctl_q[3];
                PTR_W'(4): rd_data = {ratio_q, ctl_q[4][6:3], fs_q[1], ctl_q[4][1:0]};
                PTR_W'(5): rd_data = ctl_q[5];
                PTR_W'(6): rd_data = ID_HI;
                PTR_W'(7): rd_data = ID_LO;
                default:   rd_data = 8'h00;
            endcase
        end
    end

    always_comb begin
        freq_code    = ctl_q[0][3] ? {ctl_q[0][2], ctl_q[0][6:4]} : fs_q;
        ratio_sel    = ctl_q[0][3] ? ctl_q[1][1] : ratio_q;
        spread_down  = ctl_q[0][7];
        spread_en    = ctl_q[0][1];
        tristate_all = ctl_q[0][0];
        en_fixed     = ctl_q[1][4:2];
        en_sdram_f   = ctl_q[1][0];
        en_sdram     = ctl_q[2];
        en_pci       = ctl_q[3];
        en_mid       = ctl_q[4][6:5];
        en_ioapic    = ctl_q[4][3];
        en_cpu       = ctl_q[4][1:0];
    end

    AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(strap_done_q) |-> ($stable(fs_q) && $stable(ratio_q))); // R5
    AST_FREQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(strap_done_q) && !$past(wr_en)) |-> ($stable(freq_code) && $stable(ratio_sel))); // R6
endmodule

// File: rtl/clkgen_ctrl_regs.sv
module clkgen_ctrl_regs import ccr_pkg::*; #(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         FILT_LEN = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_i,
    input  logic            sda_i,
    output logic            sda_oe,
    input  logic [FS_W-1:0] strap_fs,
    input  logic            strap_ratio,
    output logic [FS_W-1:0] freq_code,
    output logic            ratio_sel,
    output logic            spread_en,
    output logic            spread_down,
    output logic            tristate_all,
    output logic [2:0]      en_fixed,
    output logic            en_sdram_f,
    output logic [7:0]      en_sdram,
    output logic [7:0]      en_pci,
    output logic [1:0]      en_mid,
    output logic            en_ioapic,
    output logic [1:0]      en_cpu
);
    localparam int NLINE = 2;

    logic [NLINE-1:0] raw, lvl, rise, fall;
    logic [7:0]       rd_data, wr_data;
    logic [PTR_W-1:0] rd_sel;
    logic [IDX_W-1:0] wr_idx;
    logic             wr_en;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        ccr_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk(clk), .rst_n(rst_n), .line_i(raw[g]),
            .level_o(lvl[g]), .rise_o(rise[g]), .fall_o(fall[g])
        );
    end

    ccr_i2c_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .scl_lvl(lvl[0]), .scl_rise(rise[0]), .scl_fall(fall[0]),
        .sda_lvl(lvl[1]), .sda_rise(rise[1]), .sda_fall(fall[1]),
        .rd_data(rd_data), .rd_sel(rd_sel), .sda_oe(sda_oe),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    ccr_regbank u_bank (
        .clk(clk), .rst_n(rst_n),
        .strap_fs(strap_fs), .strap_ratio(strap_ratio),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .freq_code(freq_code), .ratio_sel(ratio_sel),
        .spread_en(spread_en), .spread_down(spread_down), .tristate_all(tristate_all),
        .en_fixed(en_fixed), .en_sdram_f(en_sdram_f), .en_sdram(en_sdram),
        .en_pci(en_pci), .en_mid(en_mid), .en_ioapic(en_ioapic), .en_cpu(en_cpu)
    );
endmodule

// File: tb/tb_clkgen_ctrl_regs.sv
module tb_clkgen_ctrl_regs;
    localparam int         Q   = 8;
    localparam logic [6:0] DEV = 7'h69;

    logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
    logic [3:0] s_fs = '0, l_fs = '0;
    logic s_66 = 1'b0, l_66 = 1'b0;
    logic sda_oe, ratio_sel, spread_en, spread_down, tristate_all, en_sdram_f, en_ioapic;
    logic [3:0] freq_code;
    logic [2:0] en_fixed;
    logic [7:0] en_sdram, en_pci;
    logic [1:0] en_mid, en_cpu;
    wire sda_bus = m_sda & ~sda_oe;

    int n_chk = 0, n_bad = 0;
    logic [7:0] m [6];
    logic [7:0] wbuf [12];

    always #10 clk = ~clk;

    clkgen_ctrl_regs dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .strap_fs(s_fs), .strap_ratio(s_66), .freq_code(freq_code), .ratio_sel(ratio_sel),
        .spread_en(spread_en), .spread_down(spread_down), .tristate_all(tristate_all),
        .en_fixed(en_fixed), .en_sdram_f(en_sdram_f), .en_sdram(en_sdram), .en_pci(en_pci),
        .en_mid(en_mid), .en_ioapic(en_ioapic), .en_cpu(en_cpu)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all requirements): actual hung expected completion");
        summary();
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mask_of(int i);
        return (i == 1) ? 8'h1F : (i == 4) ? 8'h7B : 8'hFF;
    endfunction

    function automatic logic [7:0] exp_view(int k);
        case (k)
            1:       return {l_fs[3], l_fs[2], l_fs[0], m[1][4:0]};
            4:       return {l_66, m[4][6:3], l_fs[1], m[4][1:0]};
            6:       return 8'h92;
            7:       return 8'h02;
            default: return m[k];
        endcase
    endfunction

    function automatic logic [32:0] exp_out();
        logic [3:0] fc;
        logic rs;
        fc = m[0][3] ? {m[0][2], m[0][6:4]} : l_fs;
        rs = m[0][3] ? m[1][1] : l_66;
        return {fc, rs, m[0][7], m[0][1], m[0][0], m[1][4:2], m[1][0],
                m[2], m[3], m[4][6:5], m[4][3], m[4][1:0]};
    endfunction

    function automatic logic [32:0] dut_out();
        return {freq_code, ratio_sel, spread_down, spread_en, tristate_all, en_fixed,
                en_sdram_f, en_sdram, en_pci, en_mid, en_ioapic, en_cpu};
    endfunction

    task automatic check_outs(string tag);
        chk(tag, 64'(dut_out()), 64'(exp_out()));
    endtask

    task automatic qw(int k = 1);
        repeat (k * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); m_sda = 1'b0; qw(); m_scl = 1'b0; qw();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qw(); m_scl = 1'b1; qw(); m_sda = 1'b1; qw(2);
    endtask

    task automatic send_bit(logic b, bit g);
        m_sda = b; qw(); m_scl = 1'b1; qw();
        if (g) begin m_sda = ~b; @(negedge clk); m_sda = b; end
        qw(); m_scl = 1'b0; qw();
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); b = sda_bus; qw(); m_scl = 1'b0; qw();
    endtask

    task automatic send_byte(logic [7:0] d, bit g, output bit ackd);
        logic bb;
        for (int i = 7; i >= 0; i--) send_bit(d[i], g && (i == 3));
        get_bit(bb);
        ackd = !bb;
    endtask

    task automatic get_byte(output logic [7:0] d, input bit ack);
        logic bb;
        for (int i = 7; i >= 0; i--) begin get_bit(bb); d[i] = bb; end
        send_bit(!ack, 1'b0);
    endtask

    // write transfer: address, command, length, then n bytes of wbuf
    task automatic wr_txn(int n, bit g, bit do_stop);
        bit a;
        bus_start();
        send_byte({DEV, 1'b0}, g, a); chk("R10 address ack", 64'(a), 64'(1));
        send_byte(8'($urandom), g, a); chk("R2 command ack", 64'(a), 64'(1));
        send_byte(8'($urandom), g, a); chk("R2 length ack", 64'(a), 64'(1));
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], g, a);
            chk($sformatf("R3 data ack %0d", i), 64'(a), 64'(1));
            if (i < 6) m[i] = (m[i] & ~mask_of(i)) | (wbuf[i] & mask_of(i));
        end
        if (do_stop) bus_stop();
    endtask

    task automatic rd_txn(int n);
        bit a;
        logic [7:0] d;
        int k;
        string tag;
        bus_start();
        send_byte({DEV, 1'b1}, 1'b0, a); chk("R9 read address ack", 64'(a), 64'(1));
        for (int i = 0; i < n; i++) begin
            get_byte(d, i < n - 1);
            k = i % 9;
            tag = (k == 0) ? "R9 length byte" : (k >= 7) ? "R4 id byte" :
                  (k == 2 || k == 5) ? "R5 strap byte" : "R3 register byte";
            chk($sformatf("%s (pos %0d)", tag, i), 64'(d),
                64'((k == 0) ? 8'h08 : exp_view(k - 1)));
        end
        bus_stop();
    endtask

    initial begin
        bit a;
        int n;
        void'($urandom(32'd4242));
        for (int i = 0; i < 6; i++) m[i] = (i == 1) ? 8'h1F : (i == 2 || i == 3) ? 8'hFF :
                                             (i == 4) ? 8'h6B : 8'h00;
        s_fs = 4'($urandom); s_66 = 1'($urandom);
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        l_fs = s_fs; l_66 = s_66;
        qw(2);
        // R1 reset defaults at the outputs and through read-back
        check_outs("R1 reset outputs");
        rd_txn(9);
        // R5 strap pins move after capture: nothing may follow them
        s_fs = ~s_fs; s_66 = ~s_66;
        qw(2);
        check_outs("R5 straps held outputs");
        rd_txn(9);
        // R4 / R5 ten zero bytes run past index 7
        for (int i = 0; i < 12; i++) wbuf[i] = 8'h00;
        wr_txn(10, 1'b0, 1'b1);
        check_outs("R8 all stopped");
        rd_txn(9);
        // R6 software frequency source
        wbuf[0] = 8'h5C;
        wr_txn(1, 1'b0, 1'b1);
        check_outs("R6 software code");
        // R7 spread and tristate bits
        wbuf[0] = 8'h83;
        wr_txn(1, 1'b0, 1'b1);
        check_outs("R7 spread/tristate");
        // random writes and full read-back
        for (int it = 0; it < 10; it++) begin
            n = $urandom_range(1, 10);
            for (int i = 0; i < 12; i++) wbuf[i] = 8'($urandom);
            wr_txn(n, 1'b0, 1'b1);
            check_outs("R6/R7/R8 random outputs");
            rd_txn(9);
        end
        // R10 foreign address
        bus_start();
        send_byte({7'h2A, 1'b0}, 1'b0, a); chk("R10 foreign address nack", 64'(a), 64'(0));
        send_byte(8'h00, 1'b0, a); chk("R10 byte after foreign address", 64'(a), 64'(0));
        send_byte(8'h00, 1'b0, a);
        bus_stop();
        check_outs("R10 bank untouched");
        // R11 START in the middle of a data byte
        wbuf[0] = 8'hA5; wbuf[1] = 8'h3C;
        wr_txn(2, 1'b0, 1'b0);
        send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0);
        wbuf[0] = 8'h5A;
        wr_txn(1, 1'b0, 1'b1);
        check_outs("R11 restart lands at index 0");
        rd_txn(9);
        // R12 one-clock SDA pulses during SCL high
        for (int i = 0; i < 12; i++) wbuf[i] = 8'($urandom);
        wr_txn(4, 1'b1, 1'b1);
        check_outs("R12 glitch ignored");
        rd_txn(9);
        // R9 early NACK releases the bus; next read restarts and wraps
        rd_txn(3);
        chk("R9 SDA released after NACK", 64'(sda_oe), 64'(0));
        rd_txn(11);
        summary();
    end
endmodule